// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block produces the active-low system reset from a digitized supply monitor. A comparator outside the block reports whether the main supply sits above the reset threshold. The block synchronizes that flag and holds reset low while the supply is bad. It releases reset only after a programmable number of millisecond ticks have been counted with the supply continuously good. The nominal delay is 250 ticks. A shorter count can be set for simulation.

When reset falls from a running state, a one-cycle strobe tells the serial interface to drop any transaction in progress. While reset stays low, the interface is expected to refuse new commands. A second output says whether a nonvolatile write that has already started may run to completion. Such a write may finish during a low-voltage reset, except when the device runs from its battery.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_n` is low, and on its release, `reset_n` is 0 and `comm_abort` is 0.
- R2: `supply_ok` passes through a two-flop synchronizer. After `supply_ok` goes low ahead of clock edge k, `reset_n` is low from edge k+2 onward.
- R3: `reset_n` rises on the clock edge that samples the DELAY_MS-th `ms_tick` counted while the synchronized supply is good. It does not rise earlier.
- R4: If the supply drops at any point during the delay, the tick count restarts from zero. A full DELAY_MS ticks are then needed after the supply returns.
- R5: While the synchronized supply is low, `reset_n` stays 0 whatever `ms_tick` does.
- R6: `comm_abort` is 1 for exactly the one cycle in which `reset_n` goes from 1 to 0. It is 0 at all other times, and so also at the release of power-up reset.
- R7: `nv_write_allow` is 0 exactly when `battery_mode` is 1 and `reset_n` is 0. Otherwise it is 1.
- R8: `battery_mode` has no effect on the timing of `reset_n`.
- R9: `ms_tick` pulses while `reset_n` is high have no effect. A later drop still needs a full DELAY_MS ticks before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset of the sequencer logic, active low |
| supply_ok | input | 1 | Asynchronous flag: main supply is above the reset threshold |
| battery_mode | input | 1 | The device is running from its backup battery |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| reset_n | output | 1 | System reset, active low |
| comm_abort | output | 1 | One-cycle strobe when a low-voltage reset begins |
| nv_write_allow | output | 1 | An in-progress nonvolatile write may complete |

## Verification
A wrong tick count shows directly on `reset_n`. The release edge moves by whole ticks, so it is visible within one tick period of the expected edge. A count that is not cleared on a supply drop shows as an early release in the next delay window. A faulty synchronizer depth moves the falling edge of `reset_n`, and with it `comm_abort`, by whole cycles. The bench therefore compares every output on every cycle against a reference model that tracks supply history.

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int DELAY_MS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic battery_mode,
  input  logic ms_tick,
  output logic reset_n,
  output logic comm_abort,
  output logic nv_write_allow
);
  localparam int CW = $clog2(DELAY_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_MS - 1);

  logic          sync_a, sync_b;
  logic [CW-1:0] ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= supply_ok;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_n <= 1'b0;
      ticks   <= '0;
    end else if (!sync_b) begin
      reset_n <= 1'b0;
      ticks   <= '0;
    end else if (!reset_n && ms_tick) begin
      if (ticks == LAST) begin
        reset_n <= 1'b1;
        ticks   <= '0;
      end else begin
        ticks <= ticks + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) comm_abort <= 1'b0;
    else        comm_abort <= reset_n && !sync_b;
  end

  assign nv_write_allow = !(battery_mode && !reset_n);
endmodule

module supply_reset_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic battery_mode,
  input logic ms_tick,
  input logic reset_n,
  input logic comm_abort,
  input logic nv_write_allow
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    comm_abort |=> !comm_abort);
  a_r6_abort_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_n) |-> comm_abort);
  a_r6_abort_only_fall: assert property (@(posedge clk) disable iff (!rst_n)
    comm_abort |-> (!reset_n && age != 2'd0 && $past(reset_n)));
  a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n) |-> $past(ms_tick));
  a_r2_low_supply_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(supply_ok, 3)) |-> !reset_n);
  a_r7_nv_block: assert property (@(posedge clk) disable iff (!rst_n)
    (battery_mode && !reset_n) |-> !nv_write_allow);
  a_r7_nv_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!battery_mode || reset_n) |-> nv_write_allow);
endmodule

bind supply_reset_seq supply_reset_seq_chk u_chk (.*);

// File: tb/test_supply_reset_seq.sv
module test_supply_reset_seq;
  localparam int D = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 1'b0, battery_mode = 1'b0, ms_tick = 1'b0;
  logic reset_n, comm_abort, nv_write_allow;

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R1 reset";

  always #4 clk = ~clk;

  supply_reset_seq #(.DELAY_MS(D)) i_supply_reset_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .battery_mode(battery_mode),
    .ms_tick(ms_tick), .reset_n(reset_n), .comm_abort(comm_abort),
    .nv_write_allow(nv_write_allow));

  // reference: pipeline of supply history and a streak of good ticks
  logic h1 = 0, h2 = 0, e_ab = 0;
  int streak = 0;
  function automatic logic exp_rn(int s); return s >= D; endfunction
  function automatic logic exp_nv(logic bm, logic rn); return !(bm && !rn); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 <= 0; h2 <= 0; streak <= 0; e_ab <= 0;
    end else begin
      h1 <= supply_ok;
      h2 <= h1;
      e_ab <= exp_rn(streak) && !h2;
      if (!h2) streak <= 0;
      else if (ms_tick && streak < D) streak <= streak + 1;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic s, logic t, logic b);
    @(negedge clk);
    supply_ok = s; ms_tick = t; battery_mode = b;
    @(negedge clk);
    ms_tick = 1'b0;
    check({phase, " reset_n"}, reset_n, exp_rn(streak));
    check({phase, " R6 comm_abort"}, comm_abort, e_ab);
    check({phase, " R7 nv_write_allow"}, nv_write_allow, exp_nv(battery_mode, exp_rn(streak)));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset_n held", reset_n, 1'b0);
    check("R1 comm_abort held", comm_abort, 1'b0);
    rst_n = 1'b1;
    phase = "R1 after release";
    step(0, 1, 0);
    // R3 power-up delay
    phase = "R3 powerup";
    for (int i = 0; i < 4; i++) step(1, 0, 0);
    for (int i = 0; i < D - 1; i++) step(1, 1, 0);
    check("R3 not before last tick", reset_n, 1'b0);
    step(1, 1, 0);
    check("R3 released on last tick", reset_n, 1'b1);
    // R9 ticks while running
    phase = "R9 ticks high";
    for (int i = 0; i < 5; i++) step(1, 1, 0);
    check("R9 still released", reset_n, 1'b1);
    // R2 drop timing, R6 abort
    phase = "R2 drop";
    @(negedge clk); supply_ok = 0;
    @(negedge clk); check("R2 edge k", reset_n, 1'b1);
    @(negedge clk); check("R2 edge k+1", reset_n, 1'b1);
    @(negedge clk); check("R2 edge k+2", reset_n, 1'b0);
    check("R6 abort with fall", comm_abort, 1'b1);
    @(negedge clk); check("R6 abort one cycle", comm_abort, 1'b0);
    // R5 ticks while low, battery R7 R8
    phase = "R5 low ticks";
    for (int i = 0; i < 2 * D; i++) step(0, 1, 1);
    check("R5 held low", reset_n, 1'b0);
    check("R7 battery blocks nv", nv_write_allow, 1'b0);
    // R4 restart mid delay
    phase = "R4 restart";
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    for (int i = 0; i < D - 2; i++) step(1, 1, 1);
    step(0, 0, 1); step(0, 0, 1); step(0, 0, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    for (int i = 0; i < D - 1; i++) step(1, 1, 1);
    check("R4 count restarted", reset_n, 1'b0);
    phase = "R8 battery release";
    step(1, 1, 1);
    check("R8 release in battery", reset_n, 1'b1);
    check("R7 nv open when running", nv_write_allow, 1'b1);
    // random mix
    phase = "R3 R4 R8 random";
    for (int i = 0; i < 4000; i++) begin
      logic s;
      s = (($urandom % 40) != 0) ? (supply_ok | (($urandom % 6) == 0)) : 1'b0;
      step(s, ($urandom % 3) == 0, $urandom % 2);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule